// File: doc/BRIEF.md
# Register-Driven Multi-Polynomial CRC Kernel

This block computes a cyclic redundancy checksum one register write at a time. At build time a parameter makes it a 32-bit engine (generator 0x04C11DB7), a 16-bit engine (generator 0x1021) or an 8-bit engine (generator 0x1D). Software first loads a starting value into the running CRC register. It then writes the message into the input register. Each accepted write folds the whole accepted data width into the running CRC in one clock cycle, through a parallel XOR network.

A configuration register holds three run-time options. The first reverses the bit order inside every input byte before the update. The second reverses the bit order of the finished CRC. The third inverts the finished CRC. The result register always shows the running CRC after these output options are applied, and reading it never disturbs the running value.

The legal width of a write to the input register depends on the kernel type. A write of a width the kernel does not allow is refused: the running CRC stays as it was, a one-cycle bus-error pulse is raised, and a sticky status bit is set. Software clears that bit by writing a one to it.

Top module: `crc_kernel`

## Requirements
- R1: Each accepted input write advances the running CRC by the full kernel width W (32, 16 or 8), taking data bits from bit W-1 down to bit 0, as a shift-left CRC with the kernel's generator (0x04C11DB7, 0x1021 or 0x1D). The result matches a bit-serial model, and the 8-bit kernel with seed 0xFF and inversion on gives 0x4B for the ASCII bytes "123456789".
- R2: A write to address 1 loads the low W bits of the write data into the running CRC, and a read of address 1 returns the running CRC, zero-extended.
- R3: When configuration bit 8 is set, each input byte is bit-reversed within its own byte lane before the update.
- R4: When configuration bit 9 is set, the result is the running CRC with its W bits in reversed order.
- R5: When configuration bit 10 is set, the result is inverted across its W bits, and the inversion is applied after any reversal from R4.
- R6: A read of the result (address 2) never changes the running CRC, and two reads in a row return the same value.
- R7: The 8-bit kernel accepts every write size code and uses only data bits 7:0.
- R8: The 16-bit kernel accepts size codes 1 (16-bit) and 2 (32-bit) and uses data bits 15:0. Size codes 0 (8-bit) and 3 are refused.
- R9: The 32-bit kernel accepts only size code 2 (32-bit). Every other size code is refused.
- R10: A refused input write leaves the running CRC unchanged, drives bus_err high in the next cycle only, and sets status bit 0 (address 4). Writing a one to status bit 0 clears it.
- R11: After reset the running CRC, the configuration, the status bit and bus_err are all zero.
- R12: The register addresses are 0 input, 1 running CRC, 2 result, 3 configuration and 4 status. A write to address 2 changes neither the CRC nor the configuration. A read of address 3 returns the configuration in bits 10:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_size | input | 2 | Write size code: 0 byte, 1 half, 2 word, 3 reserved |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Combinational read data |
| bus_err | output | 1 | One-cycle pulse after a refused input write |

## Verification
The assertions take for granted that the write strobe, address, size and data are stable and known at every rising edge outside reset. They also assume at most one write is presented per cycle, and that no status write carries a set bit 0 in the same cycle as a refused input write. The bench changes every input on the falling edge and issues one write per task call. It never overlaps a status clear with an input write, and it holds reset across the first edges, so no property is evaluated on unknown values.

// File: rtl/crc_kernel_pkg.sv
`timescale 1ns/1ps
package crc_kernel_pkg;

    typedef enum logic [1:0] {
        KIND_CRC32 = 2'd0,
        KIND_CRC16 = 2'd1,
        KIND_CRC8  = 2'd2
    } crc_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } wr_size_e;

    typedef enum logic [2:0] {
        A_INPUT  = 3'd0,
        A_SEED   = 3'd1,
        A_RESULT = 3'd2,
        A_CONFIG = 3'd3,
        A_STATUS = 3'd4
    } reg_addr_e;

    // Packed so that invert lands on bit 10, refl_out on 9, refl_in on 8.
    typedef struct packed {
        logic invert;
        logic refl_out;
        logic refl_in;
    } crc_cfg_t;

    localparam int CFG_LSB = 8;
    localparam int BUS_W   = 32;

    function automatic int crc_width(crc_kind_e k);
        case (k)
            KIND_CRC16: return 16;
            KIND_CRC8:  return 8;
            default:    return 32;
        endcase
    endfunction

    function automatic logic [31:0] crc_poly(crc_kind_e k);
        case (k)
            KIND_CRC16: return 32'h0000_1021;
            KIND_CRC8:  return 32'h0000_001D;
            default:    return 32'h04C1_1DB7;
        endcase
    endfunction

endpackage

// File: rtl/crc_size_gate.sv
`timescale 1ns/1ps
module crc_size_gate
    import crc_kernel_pkg::*;
#(
    parameter crc_kind_e KIND = KIND_CRC32
) (
    input  logic [1:0] size_i,
    output logic       legal_o
);
    generate
        if (KIND == KIND_CRC32) begin : g_word_only
            assign legal_o = (size_i == SZ_WORD);
        end else if (KIND == KIND_CRC16) begin : g_half_or_word
            assign legal_o = (size_i == SZ_HALF) || (size_i == SZ_WORD);
        end else begin : g_any
            assign legal_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/crc_step_unit.sv
`timescale 1ns/1ps
module crc_step_unit #(
    parameter int          W    = 32,
    parameter logic [31:0] POLY = 32'h04C1_1DB7
) (
    input  logic [W-1:0] crc_i,
    input  logic [W-1:0] data_i,
    input  logic         refl_in_i,
    output logic [W-1:0] next_o
);
    localparam int NBYTES = W / 8;

    logic [W-1:0] data_swapped;
    logic [W-1:0] data_eff;

    generate
        for (genvar b = 0; b < NBYTES; b++) begin : g_lane
            for (genvar j = 0; j < 8; j++) begin : g_bit
                assign data_swapped[b*8 + j] = data_i[b*8 + 7 - j];
            end
        end
    endgenerate

    assign data_eff = refl_in_i ? data_swapped : data_i;

    // Unrolled W-step recurrence; collapses to one XOR network per bit.
    always_comb begin
        logic [W-1:0] acc;
        logic         fb;
        acc = crc_i;
        for (int i = W - 1; i >= 0; i--) begin
            fb  = acc[W-1] ^ data_eff[i];
            acc = {acc[W-2:0], 1'b0};
            if (fb) acc = acc ^ POLY[W-1:0];
        end
        next_o = acc;
    end
endmodule

// File: rtl/crc_finish.sv
`timescale 1ns/1ps
module crc_finish
    import crc_kernel_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] crc_i,
    input  crc_cfg_t     cfg_i,
    output logic [W-1:0] res_o
);
    logic [W-1:0] reversed;

    generate
        for (genvar j = 0; j < W; j++) begin : g_rev
            assign reversed[j] = crc_i[W-1-j];
        end
    endgenerate

    assign res_o = (cfg_i.refl_out ? reversed : crc_i) ^ {W{cfg_i.invert}};
endmodule

// File: rtl/crc_kernel.sv
`timescale 1ns/1ps
module crc_kernel
    import crc_kernel_pkg::*;
#(
    parameter crc_kind_e KIND = KIND_CRC32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [1:0]  wr_size,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        bus_err
);
    localparam int          W    = crc_width(KIND);
    localparam logic [31:0] POLY = crc_poly(KIND);

    logic [W-1:0] crc_q;
    crc_cfg_t     cfg_q;
    logic         sts_q;
    logic         err_q;

    logic         size_ok;
    logic [W-1:0] crc_next;
    logic [W-1:0] result;
    logic         in_wr;
    logic         in_accept;
    logic         in_refuse;

    crc_size_gate #(.KIND(KIND)) u_gate (
        .size_i  (wr_size),
        .legal_o (size_ok)
    );

    crc_step_unit #(.W(W), .POLY(POLY)) u_step (
        .crc_i     (crc_q),
        .data_i    (wr_data[W-1:0]),
        .refl_in_i (cfg_q.refl_in),
        .next_o    (crc_next)
    );

    crc_finish #(.W(W)) u_finish (
        .crc_i (crc_q),
        .cfg_i (cfg_q),
        .res_o (result)
    );

    assign in_wr     = wr_en && (wr_addr == A_INPUT);
    assign in_accept = in_wr && size_ok;
    assign in_refuse = in_wr && !size_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
            cfg_q <= '0;
            sts_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            err_q <= in_refuse;
            if (in_accept) begin
                crc_q <= crc_next;
            end else if (wr_en && wr_addr == A_SEED) begin
                crc_q <= wr_data[W-1:0];
            end
            if (wr_en && wr_addr == A_CONFIG) begin
                cfg_q <= crc_cfg_t'(wr_data[CFG_LSB+2:CFG_LSB]);
            end
            if (in_refuse) begin
                sts_q <= 1'b1;
            end else if (wr_en && wr_addr == A_STATUS && wr_data[0]) begin
                sts_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            A_SEED:   rd_data = BUS_W'(crc_q);
            A_RESULT: rd_data = BUS_W'(result);
            A_CONFIG: rd_data = BUS_W'(cfg_q) << CFG_LSB;
            A_STATUS: rd_data = BUS_W'(sts_q);
            default:  rd_data = '0;
        endcase
    end

    assign bus_err = err_q;

    // Refused input write must not move the running CRC (R10).
    p_refuse_holds_crc_r10: assert property (@(posedge clk) disable iff (rst)
        in_refuse |=> $stable(crc_q));

    // Refused input write raises the pulse and the sticky bit (R10).
    p_refuse_flags_r10: assert property (@(posedge clk) disable iff (rst)
        in_refuse |=> (bus_err && sts_q));

    // Any cycle without a refused input write leaves bus_err low next (R7).
    p_accept_no_error_r7: assert property (@(posedge clk) disable iff (rst)
        !in_refuse |=> !bus_err);

    // The gate never passes a size outside the kernel's allowed set (R8, R9).
    p_legal_size_r8: assert property (@(posedge clk) disable iff (rst)
        (in_accept && KIND == KIND_CRC16) |-> (wr_size == SZ_HALF || wr_size == SZ_WORD));
    p_word_only_r9: assert property (@(posedge clk) disable iff (rst)
        (in_accept && KIND == KIND_CRC32) |-> (wr_size == SZ_WORD));

    // Seed write lands in the running CRC (R2).
    p_seed_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_SEED) |=> (crc_q == $past(wr_data[W-1:0])));

    // The result register is read-only (R12).
    p_result_write_ignored_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_RESULT) |=> ($stable(crc_q) && $stable(cfg_q)));

    // With both output options off the result equals the running CRC (R6).
    p_plain_result_r6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.refl_out && !cfg_q.invert) |-> (result == crc_q));

    // Bus error is a single-cycle pulse when no refusal follows (R10).
    p_err_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !in_refuse) |=> !bus_err);
endmodule

// File: tb/test_crc_kernel.sv
`timescale 1ns/1ps
module test_crc_kernel;
    import crc_kernel_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        we32, we16, we8;
    logic [2:0]  wr_addr;
    logic [1:0]  wr_size;
    logic [31:0] wr_data;
    logic [2:0]  rd_addr;
    logic [31:0] rd32, rd16, rd8;
    logic        be32, be16, be8;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    crc_kernel #(.KIND(KIND_CRC32)) i_crc_kernel (
        .clk(clk), .rst(rst), .wr_en(we32), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd32), .bus_err(be32));
    crc_kernel #(.KIND(KIND_CRC16)) i_crc_kernel_16 (
        .clk(clk), .rst(rst), .wr_en(we16), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd16), .bus_err(be16));
    crc_kernel #(.KIND(KIND_CRC8)) i_crc_kernel_8 (
        .clk(clk), .rst(rst), .wr_en(we8), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd8), .bus_err(be8));

    // Bit-serial reference: bytes from the top lane down, each byte MSB first.
    function automatic logic [31:0] mstep(logic [31:0] crc, logic [31:0] d, int w,
                                          logic [31:0] poly, bit rin);
        logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
        logic [7:0]  by;
        logic [7:0]  rb;
        bit          top;
        for (int b = w / 8 - 1; b >= 0; b--) begin
            by = d[b*8 +: 8];
            if (rin) begin
                for (int k = 0; k < 8; k++) rb[k] = by[7-k];
                by = rb;
            end
            for (int j = 7; j >= 0; j--) begin
                top = crc[w-1];
                crc = (crc << 1) & mask;
                if (top ^ by[j]) crc = crc ^ (poly & mask);
            end
        end
        return crc;
    endfunction

    function automatic logic [31:0] mpost(logic [31:0] crc, int w, bit rout, bit inv);
        logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
        logic [31:0] r = '0;
        if (rout) begin
            for (int k = 0; k < w; k++) r[k] = crc[w-1-k];
        end else begin
            r = crc;
        end
        if (inv) r = r ^ mask;
        return r & mask;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(int k, logic [2:0] a, logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        wr_addr = a; wr_size = s; wr_data = d;
        we32 = (k == 32); we16 = (k == 16); we8 = (k == 8);
        @(negedge clk);
        we32 = 1'b0; we16 = 1'b0; we8 = 1'b0;
    endtask

    task automatic rd(int k, logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = (k == 32) ? rd32 : (k == 16) ? rd16 : rd8;
    endtask

    function automatic logic berr(int k);
        return (k == 32) ? be32 : (k == 16) ? be16 : be8;
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        for (int k = 8; k <= 32; k = k * 2) begin
            for (int a = 1; a <= 4; a++) begin
                rd(k, 3'(a), v);
                chk($sformatf("R11 reset kernel%0d addr%0d", k, a), v, 32'h0);
            end
            chk("R11 reset bus_err", {31'b0, berr(k)}, 32'h0);
        end
    endtask

    task automatic t_crc8_check();
        string       msg = "123456789";
        logic [31:0] m = 32'hFF;
        logic [31:0] v;
        do_write(8, A_SEED, SZ_WORD, 32'hFF);
        do_write(8, A_CONFIG, SZ_WORD, 32'h400);
        for (int i = 0; i < 9; i++) begin
            do_write(8, A_INPUT, 2'(i % 4), {24'hA55AC3, msg[i]});
            m = mstep(m, {24'h0, msg[i]}, 8, 32'h1D, 0);
        end
        rd(8, A_RESULT, v);
        chk("R1 R7 crc8 check value", v, 32'h4B);
        chk("R7 crc8 against model", v, mpost(m, 8, 0, 1));
        chk("R7 crc8 no bus error", {31'b0, be8}, 32'h0);
    endtask

    task automatic t_refin();
        logic [31:0] v;
        logic [31:0] plain;
        do_write(8, A_CONFIG, SZ_WORD, 32'h0);
        do_write(8, A_SEED, SZ_BYTE, 32'h0);
        do_write(8, A_INPUT, SZ_BYTE, 32'h80);
        rd(8, A_SEED, plain);
        do_write(8, A_SEED, SZ_BYTE, 32'h0);
        do_write(8, A_CONFIG, SZ_WORD, 32'h100);
        do_write(8, A_INPUT, SZ_BYTE, 32'h01);
        rd(8, A_SEED, v);
        chk("R3 reflected 0x01 equals plain 0x80", v, plain);
        chk("R3 reflected byte model", v, mstep(0, 32'h01, 8, 32'h1D, 1));
    endtask

    task automatic t_crc32_stream();
        logic [31:0] words [4] = '{32'h31323334, 32'h35363738, 32'hDEADBEEF, 32'h00000001};
        logic [31:0] m = 32'hFFFF_FFFF;
        logic [31:0] v;
        do_write(32, A_SEED, SZ_WORD, 32'hFFFF_FFFF);
        rd(32, A_SEED, v);
        chk("R2 seed readback", v, 32'hFFFF_FFFF);
        do_write(32, A_CONFIG, SZ_WORD, 32'h700);
        foreach (words[i]) begin
            do_write(32, A_INPUT, SZ_WORD, words[i]);
            m = mstep(m, words[i], 32, 32'h04C11DB7, 1);
        end
        rd(32, A_RESULT, v);
        chk("R1 R3 R4 R5 crc32 reflected stream", v, mpost(m, 32, 1, 1));
        do_write(32, A_CONFIG, SZ_WORD, 32'h0);
        do_write(32, A_SEED, SZ_WORD, 32'h0);
        m = 32'h0;
        foreach (words[i]) begin
            do_write(32, A_INPUT, SZ_WORD, ~words[i]);
            m = mstep(m, ~words[i], 32, 32'h04C11DB7, 0);
        end
        rd(32, A_RESULT, v);
        chk("R1 crc32 plain stream", v, m);
    endtask

    task automatic t_crc32_sizes();
        logic [31:0] v;
        do_write(32, A_SEED, SZ_WORD, 32'h0BAD_F00D);
        for (int s = 0; s < 4; s++) begin
            if (s == SZ_WORD) continue;
            do_write(32, A_INPUT, 2'(s), 32'h1234_5678);
            chk($sformatf("R9 crc32 size%0d bus_err", s), {31'b0, be32}, 32'h1);
            rd(32, A_SEED, v);
            chk($sformatf("R9 R10 crc32 size%0d crc held", s), v, 32'h0BAD_F00D);
        end
        rd(32, A_STATUS, v);
        chk("R10 crc32 sticky status", v, 32'h1);
        @(negedge clk);
        chk("R10 bus_err one cycle", {31'b0, be32}, 32'h0);
        do_write(32, A_STATUS, SZ_WORD, 32'h1);
        rd(32, A_STATUS, v);
        chk("R10 status cleared", v, 32'h0);
    endtask

    task automatic t_crc16_sizes();
        logic [31:0] m = 32'hFFFF;
        logic [31:0] v;
        do_write(16, A_SEED, SZ_WORD, 32'h5555_FFFF);
        rd(16, A_SEED, v);
        chk("R2 crc16 seed low bits", v, 32'hFFFF);
        do_write(16, A_INPUT, SZ_HALF, 32'h0000_3132);
        m = mstep(m, 32'h3132, 16, 32'h1021, 0);
        chk("R8 half accepted", {31'b0, be16}, 32'h0);
        do_write(16, A_INPUT, SZ_WORD, 32'hDEAD_3334);
        m = mstep(m, 32'h3334, 16, 32'h1021, 0);
        rd(16, A_SEED, v);
        chk("R1 R8 crc16 model", v, m);
        do_write(16, A_INPUT, SZ_BYTE, 32'h35);
        chk("R8 byte refused", {31'b0, be16}, 32'h1);
        rd(16, A_SEED, v);
        chk("R8 R10 crc16 held after byte", v, m);
        do_write(16, A_STATUS, SZ_WORD, 32'h1);
        do_write(16, A_INPUT, SZ_RSVD, 32'h3536);
        chk("R8 reserved size refused", {31'b0, be16}, 32'h1);
        rd(16, A_STATUS, v);
        chk("R10 crc16 sticky status", v, 32'h1);
        rd(16, A_SEED, v);
        chk("R8 crc16 held after reserved", v, m);
    endtask

    task automatic t_post_bits();
        logic [31:0] v;
        do_write(32, A_SEED, SZ_WORD, 32'h1);
        do_write(32, A_CONFIG, SZ_WORD, 32'h200);
        rd(32, A_RESULT, v);
        chk("R4 reversal", v, 32'h8000_0000);
        do_write(32, A_CONFIG, SZ_WORD, 32'h400);
        rd(32, A_RESULT, v);
        chk("R5 inversion", v, 32'hFFFF_FFFE);
        do_write(32, A_CONFIG, SZ_WORD, 32'hFFFF_F600);
        rd(32, A_RESULT, v);
        chk("R5 reverse then invert", v, 32'h7FFF_FFFF);
        rd(32, A_CONFIG, v);
        chk("R12 config readback", v, 32'h600);
        do_write(16, A_SEED, SZ_WORD, 32'h0003);
        do_write(16, A_CONFIG, SZ_WORD, 32'h600);
        rd(16, A_RESULT, v);
        chk("R4 R5 crc16 width", v, 32'h3FFF);
    endtask

    task automatic t_result_readonly();
        logic [31:0] v1, v2;
        do_write(32, A_SEED, SZ_WORD, 32'h1234_5678);
        do_write(32, A_CONFIG, SZ_WORD, 32'h700);
        rd(32, A_RESULT, v1);
        @(negedge clk);
        rd(32, A_RESULT, v2);
        chk("R6 repeated result read", v2, v1);
        chk("R6 result value", v1, mpost(32'h1234_5678, 32, 1, 1));
        do_write(32, A_RESULT, SZ_WORD, 32'hFFFF_FFFF);
        rd(32, A_SEED, v1);
        chk("R6 R12 crc after result write", v1, 32'h1234_5678);
        rd(32, A_CONFIG, v1);
        chk("R12 config after result write", v1, 32'h700);
        rd(32, A_INPUT, v1);
        chk("R12 input reads zero", v1, 32'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all-R actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        we32 = 1'b0; we16 = 1'b0; we8 = 1'b0;
        wr_addr = '0; wr_size = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_crc8_check();
        t_refin();
        t_crc32_stream();
        t_crc32_sizes();
        t_crc16_sizes();
        t_post_bits();
        t_result_readonly();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule